// File: doc/BRIEF.md
# Temperature-Difference Fan Command Mapper

This block turns the gap between a remote temperature reading and a programmed fan threshold into a fan-speed command. A 2-bit span code chooses how many degrees of excess are needed to reach full speed: 8, 16 or 32. The same code sets the size of each command step. The command runs from 0 to 32, and it is registered one clock after the temperature inputs it reflects.

The block also holds the fan control register. The write path corrects the register's top field. Three bits of the register drive control outputs: the bus-timeout disable, the feedback-source select and the open-loop drive select. A thermal-open-loop flag is raised when open-loop drive is selected or when the external loop-open request is high. While that flag is high, the mapper result stays frozen. In its place, a speed value written through a separate port (0 to 64) goes to the output.

Top module: `fan_cmd_mapper`

## Requirements
- R1: During and right after reset, `cfg_rdata` reads 0x80, `speed_cmd` is 0, and all four control outputs are 0.
- R2: Both temperatures are signed two's-complement values. If the remote temperature is at or below the threshold, the mapper command is 0.
- R3: With d = remote minus threshold in whole degrees, the span code (register bits 6:5) sets the command. Code 00 gives 4·d, code 01 gives 2·d and code 10 gives d. The result is capped at 32, which is reached at d of 8, 16 and 32 respectively.
- R4: Span code 11 reads back as 11 but maps exactly like code 10.
- R5: Register bit 7 always reads 1. A write with bit 7 = 0 makes bits 7:5 read 100, and the other bits are written normally. Bits 4:3 are plain storage and read back as written. A write takes effect one clock later.
- R6: `bus_tmo_dis` follows register bit 2, `fb_cur_sense` follows bit 1 and `drv_open_loop` follows bit 0.
- R7: `thermal_open` is 1 whenever `drv_open_loop` is 1 or `loop_open_req` is 1. Otherwise it is 0.
- R8: While `thermal_open` is 1, `speed_cmd` shows the manually written value and the mapper result does not update. After the loop closes, `speed_cmd` shows the held mapper result until the next clock edge loads a fresh one.
- R9: A manual write stores its 8-bit value, saturated at 64, and the stored value is visible one clock later.
- R10: A change of temperature or span code shows on `speed_cmd` at the first clock edge after it. A register write and a temperature change made for the same edge map with the span code in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| man_we | input | 1 | Manual speed write strobe |
| man_wdata | input | 8 | Manual speed value |
| loop_open_req | input | 1 | External thermal-loop-open request |
| temp_remote | input | 8 | Remote temperature, signed degrees |
| temp_limit | input | 8 | Fan threshold temperature, signed degrees |
| speed_cmd | output | 7 | Fan speed command |
| bus_tmo_dis | output | 1 | Bus timeout disable |
| fb_cur_sense | output | 1 | Current-sense feedback selected |
| drv_open_loop | output | 1 | Open-loop fan drive selected |
| thermal_open | output | 1 | Thermal loop open |

## Verification
Two events can land on the same clock edge: a control register write and a temperature step that the mapper captures. The bench provokes this twice. The first time, it rewrites the span code on the same edge as a new temperature. It then expects the mapper to use the old span for that edge and the new span one edge later. The second time, it sets open-loop drive on the same edge. There it expects the value captured on that edge to be the one held and shown again once the loop closes, even though the temperature has moved in the meantime.

// File: rtl/fan_map_pkg.sv
package fan_map_pkg;

  localparam int TEMP_W   = 8;
  localparam int CMD_W    = 7;
  localparam int CMD_FULL = 32;
  localparam int MAN_MAX  = 64;
  localparam int REG_W    = 8;

  typedef enum logic [1:0] {
    SPAN_8    = 2'b00,
    SPAN_16   = 2'b01,
    SPAN_32   = 2'b10,
    SPAN_32_B = 2'b11
  } span_e;

  // Left shift applied to the excess in degrees; also right shift of full scale
  function automatic logic [1:0] span_shift(input span_e s);
    logic [1:0] r;
    case (s)
      SPAN_8:  r = 2'd2;
      SPAN_16: r = 2'd1;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fan_ctl_reg.sv
module fan_ctl_reg
  import fan_map_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output span_e         span,
  output logic          tmo_dis,
  output logic          fb_cs,
  output logic          drv_ol
);

  span_e      span_q, span_d;
  logic [1:0] spare_q, spare_d;
  logic       tmo_q, tmo_d;
  logic       fb_q, fb_d;
  logic       drv_q, drv_d;

  // next state: top bit written low forces the span field back to its base code
  always_comb begin
    span_d  = span_q;
    spare_d = spare_q;
    tmo_d   = tmo_q;
    fb_d    = fb_q;
    drv_d   = drv_q;
    if (wr_en) begin
      if (wr_data[7]) span_d = span_e'(wr_data[6:5]);
      else            span_d = SPAN_8;
      spare_d = wr_data[4:3];
      tmo_d   = wr_data[2];
      fb_d    = wr_data[1];
      drv_d   = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q  <= SPAN_8;
      spare_q <= 2'b00;
      tmo_q   <= 1'b0;
      fb_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      span_q  <= span_d;
      spare_q <= spare_d;
      tmo_q   <= tmo_d;
      fb_q    <= fb_d;
      drv_q   <= drv_d;
    end
  end

  assign rd_data = {1'b1, span_q, spare_q, tmo_q, fb_q, drv_q};
  assign span    = span_q;
  assign tmo_dis = tmo_q;
  assign fb_cs   = fb_q;
  assign drv_ol  = drv_q;

  // R5: a write with the top bit low leaves 100 in bits 7:5
  a_r5_top_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> (rd_data[7:5] == 3'b100));

  // R5: a write stores its low field one clock later
  a_r5_low_field: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4:0] == $past(wr_data[4:0])));

endmodule

// File: rtl/fan_delta_scale.sv
module fan_delta_scale
  import fan_map_pkg::*;
#(
  parameter int TW    = TEMP_W,
  parameter int CW    = CMD_W,
  parameter int FULL  = CMD_FULL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  span_e         span,
  input  logic [TW-1:0] t_rem,
  input  logic [TW-1:0] t_thr,
  output logic [CW-1:0] cmd_q
);

  localparam int DW = TW + 1;

  logic signed [DW-1:0] diff;
  logic [1:0]           sh;
  logic [DW-1:0]        lim;
  logic [CW-1:0]        cmd_nxt;
  logic [CW-1:0]        cmd_d;

  always_comb begin
    diff = $signed({t_rem[TW-1], t_rem}) - $signed({t_thr[TW-1], t_thr});
    sh   = span_shift(span);
    lim  = DW'(FULL) >> sh;
    if (diff[DW-1] || (diff == '0))
      cmd_nxt = '0;
    else if ($unsigned(diff) >= lim)
      cmd_nxt = CW'(FULL);
    else
      cmd_nxt = diff[CW-1:0] << sh;
    // clock enable: frozen while the thermal loop is open
    cmd_d = upd_en ? cmd_nxt : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  // R3: command never exceeds full scale
  a_r3_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q <= CW'(FULL));

  // R8: no update while enable is low
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cmd_q));

  // R2: no excess means zero command
  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && ($signed(t_rem) <= $signed(t_thr))) |=> (cmd_q == '0));

endmodule

// File: rtl/fan_cmd_select.sv
module fan_cmd_select
  import fan_map_pkg::*;
#(
  parameter int CW   = CMD_W,
  parameter int IW   = 8,
  parameter int MMAX = MAN_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_ol,
  input  logic          open_req,
  input  logic          man_we,
  input  logic [IW-1:0] man_wdata,
  input  logic [CW-1:0] map_cmd,
  output logic          thermal_open,
  output logic [CW-1:0] speed_cmd
);

  logic [CW-1:0] man_q, man_d, man_cap;

  always_comb begin
    man_cap = (man_wdata > IW'(MMAX)) ? CW'(MMAX) : man_wdata[CW-1:0];
    man_d   = man_we ? man_cap : man_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) man_q <= '0;
    else        man_q <= man_d;
  end

  assign thermal_open = drv_ol | open_req;
  assign speed_cmd    = thermal_open ? man_q : map_cmd;

  // R9: stored manual value stays within range
  a_r9_man_cap: assert property (@(posedge clk) disable iff (!rst_n)
    man_q <= CW'(MMAX));

  // R7: open-loop drive always opens the thermal loop
  a_r7_drv_opens: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ol |-> thermal_open);

endmodule

// File: rtl/fan_cmd_mapper.sv
module fan_cmd_mapper
  import fan_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             man_we,
  input  logic [7:0]       man_wdata,
  input  logic             loop_open_req,
  input  logic [TEMP_W-1:0] temp_remote,
  input  logic [TEMP_W-1:0] temp_limit,
  output logic [CMD_W-1:0] speed_cmd,
  output logic             bus_tmo_dis,
  output logic             fb_cur_sense,
  output logic             drv_open_loop,
  output logic             thermal_open
);

  span_e            span;
  logic [CMD_W-1:0] map_cmd;
  logic             drv_ol;

  fan_ctl_reg #(.DW(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .span    (span),
    .tmo_dis (bus_tmo_dis),
    .fb_cs   (fb_cur_sense),
    .drv_ol  (drv_ol)
  );

  fan_delta_scale #(.TW(TEMP_W), .CW(CMD_W), .FULL(CMD_FULL)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (!thermal_open),
    .span   (span),
    .t_rem  (temp_remote),
    .t_thr  (temp_limit),
    .cmd_q  (map_cmd)
  );

  fan_cmd_select #(.CW(CMD_W), .IW(8), .MMAX(MAN_MAX)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .drv_ol       (drv_ol),
    .open_req     (loop_open_req),
    .man_we       (man_we),
    .man_wdata    (man_wdata),
    .map_cmd      (map_cmd),
    .thermal_open (thermal_open),
    .speed_cmd    (speed_cmd)
  );

  assign drv_open_loop = drv_ol;

  // R5: top register bit reads one at all times
  a_r5_top_one: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7]);

endmodule

// File: tb/tb_fan_cmd_mapper.sv
module tb_fan_cmd_mapper;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       man_we;
  logic [7:0] man_wdata;
  logic       loop_open_req;
  logic [7:0] temp_remote;
  logic [7:0] temp_limit;
  logic [6:0] speed_cmd;
  logic       bus_tmo_dis, fb_cur_sense, drv_open_loop, thermal_open;

  fan_cmd_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .man_we(man_we), .man_wdata(man_wdata),
    .loop_open_req(loop_open_req), .temp_remote(temp_remote),
    .temp_limit(temp_limit), .speed_cmd(speed_cmd), .bus_tmo_dis(bus_tmo_dis),
    .fb_cur_sense(fb_cur_sense), .drv_open_loop(drv_open_loop),
    .thermal_open(thermal_open)
  );

  always #(CLK_P/2) clk = ~clk;

  // sel: 0 = speed_cmd, 1 = cfg_rdata, 2 = {tmo, fb, drv, thermal_open}
  typedef struct {
    int    due;
    int    sel;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic int actual(int sel);
    if (sel == 0) return int'(speed_cmd);
    if (sel == 1) return int'(cfg_rdata);
    return int'({bus_tmo_dis, fb_cur_sense, drv_open_loop, thermal_open});
  endfunction

  task automatic check(int sel, int val, string tag);
    int a;
    a = actual(sel);
    n_run++;
    if (a !== val) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, sel, a, val);
    end
  endtask

  // expected mapper result from the requirements
  function automatic int exp_map(int rem, int thr, int code);
    int d, stp;
    d = rem - thr;
    if (d <= 0) return 0;
    stp = (code == 0) ? 4 : (code == 1) ? 2 : 1;
    if (d * stp >= 32) return 32;
    return d * stp;
  endfunction

  task automatic expect_at(int off, int sel, int val, string tag);
    exp_t e;
    e.due = cyc + off; e.sel = sel; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(bit we, logic [7:0] cfg, bit mwe, logic [7:0] md,
                      int rem, int thr, bit oreq);
    @(negedge clk);
    cfg_we        = we;
    cfg_wdata     = cfg;
    man_we        = mwe;
    man_wdata     = md;
    temp_remote   = 8'(rem);
    temp_limit    = 8'(thr);
    loop_open_req = oreq;
  endtask

  // monitor: compare items as their cycle comes due
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.sel, e.val, e.tag);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; man_we = 1'b0; man_wdata = '0;
    loop_open_req = 1'b0; temp_remote = '0; temp_limit = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check(1, 8'h80, "R1 rd");
    check(0, 0, "R1 speed");
    check(2, 0, "R1 ctl");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: at or below threshold, signed
    step(0, 0, 0, 0, 30, 40, 0);  expect_at(1, 0, 0, "R2 below");
    step(0, 0, 0, 0, 40, 40, 0);  expect_at(1, 0, 0, "R2 equal");
    step(0, 0, 0, 0, -40, -20, 0); expect_at(1, 0, 0, "R2 neg below");
    step(0, 0, 0, 0, -10, -12, 0); expect_at(1, 0, exp_map(-10, -12, 0), "R2 R3 signed excess");

    // R3: span code 00
    step(0, 0, 0, 0, 42, 40, 0);  expect_at(1, 0, exp_map(42, 40, 0), "R3 code00 d2");
    step(0, 0, 0, 0, 47, 40, 0);  expect_at(1, 0, exp_map(47, 40, 0), "R3 code00 d7");
    step(0, 0, 0, 0, 48, 40, 0);  expect_at(1, 0, 32, "R3 code00 d8 full");
    step(0, 0, 0, 0, 100, 40, 0); expect_at(1, 0, 32, "R3 code00 sat");

    // R10: span write and temperature step on the same edge
    step(1, 8'hA0, 0, 0, 45, 40, 0);
    expect_at(1, 0, exp_map(45, 40, 0), "R10 old span same edge");
    expect_at(1, 1, 8'hA0, "R5 rd A0");
    step(0, 0, 0, 0, 45, 40, 0);  expect_at(1, 0, exp_map(45, 40, 1), "R3 R10 code01 d5");
    step(0, 0, 0, 0, 55, 40, 0);  expect_at(1, 0, exp_map(55, 40, 1), "R3 code01 d15");
    step(0, 0, 0, 0, 56, 40, 0);  expect_at(1, 0, 32, "R3 code01 d16 full");

    // code 10
    step(1, 8'hC0, 0, 0, 45, 40, 0); expect_at(1, 1, 8'hC0, "R5 rd C0");
    step(0, 0, 0, 0, 45, 40, 0);  expect_at(1, 0, exp_map(45, 40, 2), "R3 code10 d5");
    step(0, 0, 0, 0, 71, 40, 0);  expect_at(1, 0, 31, "R3 code10 d31");
    step(0, 0, 0, 0, 72, 40, 0);  expect_at(1, 0, 32, "R3 code10 d32 full");

    // R4: code 11 behaves as 10
    step(1, 8'hE0, 0, 0, 45, 40, 0); expect_at(1, 1, 8'hE0, "R4 rd E0");
    step(0, 0, 0, 0, 45, 40, 0);  expect_at(1, 0, 5, "R4 code11 d5");
    step(0, 0, 0, 0, 60, 40, 0);  expect_at(1, 0, 20, "R4 code11 d20");
    step(0, 0, 0, 0, 45, 40, 0);  expect_at(1, 0, 5, "R4 code11 back d5");

    // R5/R6/R7: top bit low, all control bits set, loop opens same edge
    step(1, 8'h5F, 0, 0, 45, 40, 0);
    expect_at(1, 1, 8'h9F, "R5 top fix");
    expect_at(1, 2, 4'hF, "R6 R7 ctl all");
    expect_at(1, 0, 0, "R8 manual shown");

    // R9: manual writes and saturation; R8 temperature ignored
    step(0, 0, 1, 8'd50, 45, 40, 0);  expect_at(1, 0, 50, "R9 manual 50");
    step(0, 0, 1, 8'd100, 45, 40, 0); expect_at(1, 0, 64, "R9 manual sat");
    step(0, 0, 1, 8'd64, 43, 40, 0);  expect_at(1, 0, 64, "R9 manual 64");
    step(0, 0, 0, 0, 43, 40, 0);      expect_at(1, 0, 64, "R8 temp ignored");

    // R8: close loop; held value first, then fresh map with code 00
    step(1, 8'h80, 0, 0, 43, 40, 0);
    expect_at(1, 1, 8'h80, "R5 rd 80");
    expect_at(1, 2, 0, "R6 ctl clear");
    expect_at(1, 0, 5, "R8 held value");
    step(0, 0, 0, 0, 43, 40, 0);  expect_at(1, 0, exp_map(43, 40, 0), "R8 fresh after close");

    // R7: external request opens the loop
    step(0, 0, 0, 0, 43, 40, 1);
    expect_at(1, 2, 4'h1, "R7 req open");
    expect_at(1, 0, 64, "R7 R8 manual via req");
    step(0, 0, 0, 0, 43, 40, 0);  expect_at(1, 0, 12, "R7 req closed");

    // R6: individual control bits
    step(1, 8'h84, 0, 0, 43, 40, 0);
    expect_at(1, 2, 4'h8, "R6 timeout bit");
    expect_at(1, 1, 8'h84, "R6 rd 84");
    step(1, 8'h82, 0, 0, 43, 40, 0);
    expect_at(1, 2, 4'h4, "R6 feedback bit");
    expect_at(1, 0, 12, "R6 feedback no effect on map");
    step(1, 8'h98, 0, 0, 41, 40, 0);
    expect_at(1, 1, 8'h98, "R5 spare bits stored");
    expect_at(1, 0, 4, "R10 one edge latency");

    step(0, 0, 0, 0, 41, 40, 0);
    repeat (3) @(negedge clk);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL queue actual=%0d expected=0 pending", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule